// File: doc/BRIEF.md
# Disk and Packet DMA Transfer Sequencer

This block steers one bus-master transfer between a storage data path and a descriptor-driven DMA channel. A start pulse latches the drive kind (fixed disk or packet device), the command, the starting block address and the size: a sector count for a disk, a byte count for a packet device. It also clears the running byte index and marks the transfer active. After that, every buffer descriptor (address, length) the channel presents becomes one chunk. The sequencer works out the byte offset into the medium and issues one read, write or trim sub-operation. It then moves the remaining and index counters on by the descriptor length.

When a sub-operation completes, the sequencer either hands the chunk back to the channel and waits for the next descriptor, or ends the transfer. A disk ends with a ready/seek-complete status and an interrupt. A packet device ends with a plain completion pulse. Three other paths exist. A packet transfer whose block address is all ones is a non-block transfer: it is served by one direct copy. A descriptor that arrives while the sequencer is inactive is returned without any effect. Failures, and command codes the sequencer does not know, end the transfer with an error.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, `active`, `irq`, `op_valid`, `chunk_end`, `done_ok`, `done_err` and `bad_cmd` are 0 and `status` is 8'h00.
- R2: A `start` pulse makes `active` 1 in the next cycle and clears `irq` and `status`. It loads the remaining size (`sec_count`×512 for a disk, `pkt_size` for a packet device) and sets the byte index to 0.
- R3: For a disk, an accepted descriptor gives a one-cycle `op_valid` in the next cycle with `op_offset` = `lba`×512 + index, `op_addr`/`op_len` equal to the descriptor, and `op_kind` = `cmd` (0 read, 1 write, 2 trim).
- R4: For a packet device, the issued offset is `lba`×2048 + index, and `op_kind` is always 0 (read).
- R5: Each issued sub-operation lowers the remaining size by the descriptor length and raises the index by the same amount. The index is visible in the next chunk's offset.
- R6: If `op_done` (without `op_err`) arrives and the remaining size is zero or negative, then in the next cycle `done_ok` and `chunk_end` pulse and `active` drops. A disk also sets `status` to 8'h50 and `irq` to 1. A packet device leaves both unchanged.
- R7: If `op_done` arrives and the remaining size is still positive, only `chunk_end` pulses and the transfer stays active.
- R8: A zero-length descriptor pulses `chunk_end`, issues nothing, and leaves the counters and the active state as they were.
- R9: A descriptor presented while inactive pulses `chunk_end` and issues nothing.
- R10: For a packet device with `lba` all ones, a descriptor issues `op_kind` 3 (direct copy) with `op_len` = min(remaining, descriptor length). `done_ok` pulses in the same cycle and the transfer ends.
- R11: For a disk with `cmd` 3, a descriptor issues nothing. It pulses `bad_cmd` and `done_err`, sets `status` to 8'h51 and `irq` to 1, and ends the transfer.
- R12: `op_done` together with `op_err` ends the transfer with `done_err`. A disk also sets `status` to 8'h51 and `irq` to 1.
- R13: A descriptor that arrives while the remaining size is already zero ends the transfer as in R6, with no sub-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer and latch the parameters |
| is_packet | input | 1 | 1 = packet device, 0 = disk |
| cmd | input | 2 | Disk command: 0 read, 1 write, 2 trim, 3 unsupported |
| lba | input | LBA_W | Starting block address |
| sec_count | input | CNT_W | Disk sector count |
| pkt_size | input | PKT_W | Packet transfer byte count |
| desc_valid | input | 1 | Descriptor presented for one cycle |
| desc_addr | input | ADDR_W | Descriptor buffer address |
| desc_len | input | LEN_W | Descriptor byte length |
| op_done | input | 1 | Sub-operation finished |
| op_err | input | 1 | Sub-operation failed (qualified by op_done) |
| active | output | 1 | Transfer in progress |
| op_valid | output | 1 | Sub-operation request pulse |
| op_kind | output | 2 | 0 read, 1 write, 2 trim, 3 direct copy |
| op_offset | output | LBA_W+12 | Byte offset into the medium |
| op_addr | output | ADDR_W | Buffer address for the sub-operation |
| op_len | output | LEN_W | Byte length for the sub-operation |
| chunk_end | output | 1 | Descriptor handed back to the channel |
| done_ok | output | 1 | Transfer ended successfully |
| done_err | output | 1 | Transfer ended with an error |
| bad_cmd | output | 1 | Unsupported command code seen |
| status | output | 8 | Disk completion status |
| irq | output | 1 | Disk completion interrupt |

## Verification
The disk path is driven with read, write and trim commands over two-chunk and one-chunk transfers. This separates the command-to-kind mapping and shows, through the second offset, that the index moves forward. A packet transfer whose last descriptor overshoots the remaining size checks the ×2048 scaling and the ending on a negative count. Separate cases cover zero-length descriptors, descriptors presented while inactive, a zero sector count, the direct-copy path with a short remaining size, an unsupported command and a failing sub-operation. Each of these is told apart by which pulse appears without `op_valid`, and by the disk status code.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TRIM  = 2'd2,
        OP_COPY  = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_DESC = 2'd1,
        ST_WAIT_OP   = 2'd2
    } seq_state_e;

    localparam logic [7:0] STAT_CLEAR = 8'h00;
    localparam logic [7:0] STAT_READY = 8'h50;
    localparam logic [7:0] STAT_FAULT = 8'h51;
endpackage

// File: rtl/dxs_offset_calc.sv
module dxs_offset_calc #(
    parameter int LBA_W = 32,
    parameter int IDX_W = 19,
    parameter int OFF_W = LBA_W + 12
) (
    input  logic             is_packet,
    input  logic [LBA_W-1:0] lba,
    input  logic [IDX_W-1:0] idx,
    output logic [OFF_W-1:0] offset
);
    localparam int DISK_SH = 9;
    localparam int PKT_SH  = 11;

    logic [OFF_W-1:0] base_disk;
    logic [OFF_W-1:0] base_pkt;
    logic [OFF_W-1:0] idx_ext;

    always_comb begin
        base_disk = OFF_W'(lba) << DISK_SH;
        base_pkt  = OFF_W'(lba) << PKT_SH;
        idx_ext   = OFF_W'(idx);
        offset    = (is_packet ? base_pkt : base_disk) + idx_ext;
    end
endmodule

// File: rtl/dxs_counters.sv
module dxs_counters #(
    parameter int REM_W = 19,
    parameter int LEN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [REM_W-2:0]        load_val,
    input  logic                    step,
    input  logic [LEN_W-1:0]        step_len,
    output logic signed [REM_W-1:0] remaining,
    output logic [REM_W-1:0]        index,
    output logic                    exhausted
);
    typedef struct packed {
        logic signed [REM_W-1:0] rem;
        logic [REM_W-1:0]        idx;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.rem = $signed({1'b0, load_val});
            cnt_d.idx = '0;
        end else if (step) begin
            cnt_d.rem = cnt_q.rem - $signed(REM_W'(step_len));
            cnt_d.idx = cnt_q.idx + REM_W'(step_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign remaining = cnt_q.rem;
    assign index     = cnt_q.idx;
    assign exhausted = (cnt_q.rem <= 0);

    // R5: a step never makes the remaining size larger
    p_rem_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (remaining <= $past(remaining)));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
    parameter int LBA_W  = 32,
    parameter int CNT_W  = 8,
    parameter int PKT_W  = 16,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                is_packet,
    input  logic [1:0]          cmd,
    input  logic [LBA_W-1:0]    lba,
    input  logic [CNT_W-1:0]    sec_count,
    input  logic [PKT_W-1:0]    pkt_size,
    input  logic                desc_valid,
    input  logic [ADDR_W-1:0]   desc_addr,
    input  logic [LEN_W-1:0]    desc_len,
    input  logic                op_done,
    input  logic                op_err,
    output logic                active,
    output logic                op_valid,
    output logic [1:0]          op_kind,
    output logic [LBA_W+11:0]   op_offset,
    output logic [ADDR_W-1:0]   op_addr,
    output logic [LEN_W-1:0]    op_len,
    output logic                chunk_end,
    output logic                done_ok,
    output logic                done_err,
    output logic                bad_cmd,
    output logic [7:0]          status,
    output logic                irq
);
    import dxs_pkg::*;

    localparam int DISK_W = CNT_W + 9;
    localparam int SZ_W   = (DISK_W > PKT_W) ? DISK_W : PKT_W;
    localparam int MAG_W  = (SZ_W > LEN_W) ? SZ_W : LEN_W;
    localparam int REM_W  = MAG_W + 2;
    localparam int OFF_W  = LBA_W + 12;

    typedef struct packed {
        seq_state_e        state;
        logic              pkt;
        logic [1:0]        cmd;
        logic [LBA_W-1:0]  lba;
        logic              op_valid;
        op_kind_e          op_kind;
        logic [OFF_W-1:0]  op_offset;
        logic [ADDR_W-1:0] op_addr;
        logic [LEN_W-1:0]  op_len;
        logic              chunk_end;
        logic              done_ok;
        logic              done_err;
        logic              bad_cmd;
        logic [7:0]        status;
        logic              irq;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                    cnt_load;
    logic                    cnt_step;
    logic [REM_W-2:0]        load_val;
    logic signed [REM_W-1:0] remaining;
    logic [REM_W-1:0]        index;
    logic                    exhausted;
    logic [OFF_W-1:0]        calc_off;
    logic [LEN_W-1:0]        copy_len;
    logic                    fin_ok;
    logic                    fin_err;
    logic                    non_block;

    always_comb begin
        if (is_packet) load_val = (REM_W-1)'(pkt_size);
        else           load_val = (REM_W-1)'(sec_count) << 9;
    end

    dxs_counters #(.REM_W(REM_W), .LEN_W(LEN_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_val  (load_val),
        .step      (cnt_step),
        .step_len  (desc_len),
        .remaining (remaining),
        .index     (index),
        .exhausted (exhausted)
    );

    dxs_offset_calc #(.LBA_W(LBA_W), .IDX_W(REM_W), .OFF_W(OFF_W)) u_off (
        .is_packet (seq_q.pkt),
        .lba       (seq_q.lba),
        .idx       (index),
        .offset    (calc_off)
    );

    assign non_block = seq_q.pkt && (&seq_q.lba);

    always_comb begin
        if (remaining < $signed(REM_W'(desc_len))) copy_len = LEN_W'(remaining);
        else                                        copy_len = desc_len;
    end

    always_comb begin
        seq_d           = seq_q;
        seq_d.op_valid  = 1'b0;
        seq_d.chunk_end = 1'b0;
        seq_d.done_ok   = 1'b0;
        seq_d.done_err  = 1'b0;
        seq_d.bad_cmd   = 1'b0;
        cnt_load        = 1'b0;
        cnt_step        = 1'b0;
        fin_ok          = 1'b0;
        fin_err         = 1'b0;

        if (start) begin
            seq_d.state  = ST_WAIT_DESC;
            seq_d.pkt    = is_packet;
            seq_d.cmd    = cmd;
            seq_d.lba    = lba;
            seq_d.status = STAT_CLEAR;
            seq_d.irq    = 1'b0;
            cnt_load     = 1'b1;
        end else begin
            unique case (seq_q.state)
                ST_IDLE: begin
                    if (desc_valid) seq_d.chunk_end = 1'b1;
                end
                ST_WAIT_DESC: begin
                    if (desc_valid) begin
                        if (exhausted) begin
                            fin_ok = 1'b1;
                        end else if (desc_len == '0) begin
                            seq_d.chunk_end = 1'b1;
                        end else if (non_block) begin
                            seq_d.op_valid = 1'b1;
                            seq_d.op_kind  = OP_COPY;
                            seq_d.op_addr  = desc_addr;
                            seq_d.op_len   = copy_len;
                            fin_ok         = 1'b1;
                        end else if (!seq_q.pkt && seq_q.cmd == 2'd3) begin
                            seq_d.bad_cmd = 1'b1;
                            fin_err       = 1'b1;
                        end else begin
                            seq_d.op_valid  = 1'b1;
                            seq_d.op_kind   = seq_q.pkt ? OP_READ : op_kind_e'(seq_q.cmd);
                            seq_d.op_offset = calc_off;
                            seq_d.op_addr   = desc_addr;
                            seq_d.op_len    = desc_len;
                            seq_d.state     = ST_WAIT_OP;
                            cnt_step        = 1'b1;
                        end
                    end
                end
                ST_WAIT_OP: begin
                    if (op_done) begin
                        seq_d.chunk_end = 1'b1;
                        if (op_err)         fin_err = 1'b1;
                        else if (exhausted) fin_ok = 1'b1;
                        else                seq_d.state = ST_WAIT_DESC;
                    end
                end
                default: seq_d.state = ST_IDLE;
            endcase

            if (fin_ok) begin
                seq_d.state   = ST_IDLE;
                seq_d.done_ok = 1'b1;
                if (!seq_q.pkt) begin
                    seq_d.status = STAT_READY;
                    seq_d.irq    = 1'b1;
                end
            end
            if (fin_err) begin
                seq_d.state    = ST_IDLE;
                seq_d.done_err = 1'b1;
                if (!seq_q.pkt) begin
                    seq_d.status = STAT_FAULT;
                    seq_d.irq    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active    = (seq_q.state != ST_IDLE);
    assign op_valid  = seq_q.op_valid;
    assign op_kind   = seq_q.op_kind;
    assign op_offset = seq_q.op_offset;
    assign op_addr   = seq_q.op_addr;
    assign op_len    = seq_q.op_len;
    assign chunk_end = seq_q.chunk_end;
    assign done_ok   = seq_q.done_ok;
    assign done_err  = seq_q.done_err;
    assign bad_cmd   = seq_q.bad_cmd;
    assign status    = seq_q.status;
    assign irq       = seq_q.irq;

    // R6: a successful ending leaves the sequencer inactive
    p_ok_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |-> !active);
    // R12: the two endings are exclusive
    p_one_ending_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && done_err));
    // R3: a block sub-operation keeps the transfer waiting for its completion
    p_block_op_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != 2'd3) |-> active);
    // R11: an unsupported command issues nothing
    p_bad_no_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |-> (!op_valid && done_err));
    // R6: the interrupt only rises together with an ending
    p_irq_with_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (done_ok || done_err));
    // R8: a returned chunk never carries a request
    p_chunk_no_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(chunk_end && op_valid));
endmodule

// File: tb/dma_xfer_seq_tb.sv
module dma_xfer_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LBA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, is_packet = 1'b0;
    logic [1:0] cmd = '0;
    logic [LBA_W-1:0] lba = '0;
    logic [7:0] sec_count = '0;
    logic [15:0] pkt_size = '0;
    logic desc_valid = 1'b0;
    logic [31:0] desc_addr = '0;
    logic [15:0] desc_len = '0;
    logic op_done = 1'b0, op_err = 1'b0;
    logic active, op_valid, chunk_end, done_ok, done_err, bad_cmd, irq;
    logic [1:0] op_kind;
    logic [LBA_W+11:0] op_offset;
    logic [31:0] op_addr;
    logic [15:0] op_len;
    logic [7:0] status;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .is_packet(is_packet),
        .cmd(cmd), .lba(lba), .sec_count(sec_count), .pkt_size(pkt_size),
        .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_len(desc_len),
        .op_done(op_done), .op_err(op_err), .active(active),
        .op_valid(op_valid), .op_kind(op_kind), .op_offset(op_offset),
        .op_addr(op_addr), .op_len(op_len), .chunk_end(chunk_end),
        .done_ok(done_ok), .done_err(done_err), .bad_cmd(bad_cmd),
        .status(status), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_start(input logic pkt, input logic [1:0] c,
                            input logic [LBA_W-1:0] l, input logic [7:0] n,
                            input logic [15:0] p);
        @(negedge clk);
        start = 1'b1; is_packet = pkt; cmd = c; lba = l; sec_count = n; pkt_size = p;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "active after start", longint'(active), 1);
        chk("R2", "irq after start", longint'(irq), 0);
        chk("R2", "status after start", longint'(status), 0);
    endtask

    task automatic send_desc(input logic [31:0] a, input logic [15:0] n);
        @(negedge clk);
        desc_valid = 1'b1; desc_addr = a; desc_len = n;
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic finish_op(input logic e);
        @(negedge clk);
        op_done = 1'b1; op_err = e;
        @(negedge clk);
        op_done = 1'b0; op_err = 1'b0;
    endtask

    task automatic expect_op(input string req, input longint kind,
                             input longint off, input longint a, input longint n);
        chk(req, "op_valid", longint'(op_valid), 1);
        chk(req, "op_kind", longint'(op_kind), kind);
        chk(req, "op_offset", longint'(op_offset), off);
        chk(req, "op_addr", longint'(op_addr), a);
        chk(req, "op_len", longint'(op_len), n);
    endtask

    task automatic t_reset();
        chk("R1", "active", longint'(active), 0);
        chk("R1", "irq", longint'(irq), 0);
        chk("R1", "status", longint'(status), 0);
        chk("R1", "pulses", longint'({op_valid, chunk_end, done_ok, done_err, bad_cmd}), 0);
    endtask

    task automatic t_disk_read();
        do_start(1'b0, 2'd0, 32'd3, 8'd2, 16'd0);
        send_desc(32'h1000, 16'd512);
        expect_op("R3", 0, 1536, 32'h1000, 512);
        finish_op(1'b0);
        chk("R7", "chunk_end", longint'(chunk_end), 1);
        chk("R7", "done_ok", longint'(done_ok), 0);
        chk("R7", "active", longint'(active), 1);
        send_desc(32'h2000, 16'd512);
        expect_op("R5", 0, 2048, 32'h2000, 512);
        finish_op(1'b0);
        chk("R6", "done_ok", longint'(done_ok), 1);
        chk("R6", "chunk_end", longint'(chunk_end), 1);
        chk("R6", "active", longint'(active), 0);
        chk("R6", "status", longint'(status), 8'h50);
        chk("R6", "irq", longint'(irq), 1);
    endtask

    task automatic t_disk_write_zero_len();
        do_start(1'b0, 2'd1, 32'd10, 8'd1, 16'd0);
        send_desc(32'h3000, 16'd0);
        chk("R8", "chunk_end", longint'(chunk_end), 1);
        chk("R8", "op_valid", longint'(op_valid), 0);
        chk("R8", "active", longint'(active), 1);
        send_desc(32'h3400, 16'd512);
        expect_op("R8", 1, 5120, 32'h3400, 512);
        finish_op(1'b0);
        chk("R6", "write done_ok", longint'(done_ok), 1);
    endtask

    task automatic t_disk_trim();
        do_start(1'b0, 2'd2, 32'd1, 8'd1, 16'd0);
        send_desc(32'h4000, 16'd512);
        expect_op("R3", 2, 512, 32'h4000, 512);
        finish_op(1'b0);
        chk("R6", "trim done_ok", longint'(done_ok), 1);
    endtask

    task automatic t_packet();
        do_start(1'b1, 2'd1, 32'd2, 8'd0, 16'd3000);
        send_desc(32'h5000, 16'd2048);
        expect_op("R4", 0, 4096, 32'h5000, 2048);
        finish_op(1'b0);
        chk("R7", "pkt chunk_end", longint'(chunk_end), 1);
        chk("R7", "pkt active", longint'(active), 1);
        send_desc(32'h6000, 16'd1024);
        expect_op("R5", 0, 6144, 32'h6000, 1024);
        finish_op(1'b0);
        chk("R6", "pkt done_ok", longint'(done_ok), 1);
        chk("R6", "pkt irq", longint'(irq), 0);
        chk("R6", "pkt status", longint'(status), 0);
        chk("R6", "pkt active", longint'(active), 0);
    endtask

    task automatic t_idle_desc();
        send_desc(32'h7000, 16'd512);
        chk("R9", "chunk_end", longint'(chunk_end), 1);
        chk("R9", "op_valid", longint'(op_valid), 0);
        chk("R9", "active", longint'(active), 0);
    endtask

    task automatic t_copy();
        do_start(1'b1, 2'd0, 32'hFFFF_FFFF, 8'd0, 16'd100);
        send_desc(32'h8000, 16'd512);
        chk("R10", "op_valid", longint'(op_valid), 1);
        chk("R10", "op_kind", longint'(op_kind), 3);
        chk("R10", "op_len", longint'(op_len), 100);
        chk("R10", "op_addr", longint'(op_addr), 32'h8000);
        chk("R10", "done_ok", longint'(done_ok), 1);
        chk("R10", "active", longint'(active), 0);
    endtask

    task automatic t_bad_cmd();
        do_start(1'b0, 2'd3, 32'd4, 8'd1, 16'd0);
        send_desc(32'h9000, 16'd512);
        chk("R11", "op_valid", longint'(op_valid), 0);
        chk("R11", "bad_cmd", longint'(bad_cmd), 1);
        chk("R11", "done_err", longint'(done_err), 1);
        chk("R11", "status", longint'(status), 8'h51);
        chk("R11", "irq", longint'(irq), 1);
    endtask

    task automatic t_op_error();
        do_start(1'b0, 2'd0, 32'd5, 8'd4, 16'd0);
        send_desc(32'hA000, 16'd512);
        expect_op("R12", 0, 2560, 32'hA000, 512);
        finish_op(1'b1);
        chk("R12", "done_err", longint'(done_err), 1);
        chk("R12", "done_ok", longint'(done_ok), 0);
        chk("R12", "status", longint'(status), 8'h51);
        chk("R12", "active", longint'(active), 0);
    endtask

    task automatic t_zero_count();
        do_start(1'b0, 2'd0, 32'd6, 8'd0, 16'd0);
        send_desc(32'hB000, 16'd512);
        chk("R13", "op_valid", longint'(op_valid), 0);
        chk("R13", "done_ok", longint'(done_ok), 1);
        chk("R13", "status", longint'(status), 8'h50);
        chk("R13", "active", longint'(active), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disk_read();
        t_disk_write_zero_len();
        t_disk_trim();
        t_packet();
        t_idle_desc();
        t_copy();
        t_bad_cmd();
        t_op_error();
        t_zero_count();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule